// File: doc/BRIEF.md
# Branch Clock Gating Controller

This block decides, cycle by cycle, whether one branch clock taken from a base clock runs or stops, and gates that clock without glitches. A three-bit control word holds a run bit, an auto bit that makes shutdown wait for the bus to drain, and a wake bit that lets the clock follow a chip-wide power-down request. When the wake bit is set, power-down stops the clock. A wake event or the end of power-down starts it again.

When shutdown goes through the bus-drain path, the block raises a drain request and keeps the clock running until the fabric acknowledges. The request stays high while the clock is stopped and drops when the clock comes back. If the clock is wanted again while the request is still unanswered, the shutdown is cancelled. A status word reports the enable state actually applied, which can lag the control word. Any control bit can be fixed per instance through parameters.

Top module: `branch_clk_gate`

## Requirements
- R1: After reset the control word reads 3'b001 (run=bit0 set, auto=bit1 clear, wake=bit2 clear), the clock is enabled and the drain request is low.
- R2: A write with `reg_addr`=0 stores `wr_data[2:0]` in the control word. Reads at `reg_addr`=0 return the control word in bits 2:0 and zeros in all higher bits. The new word acts from the next cycle on.
- R3: With run=0 and auto=0, the clock enable is low one cycle after the control word changes. Setting run=1 again re-enables the clock one cycle later.
- R4: With wake=0, `pwr_down` has no effect on the clock. With wake=1 and run=1, a high `pwr_down` stops the clock one cycle later.
- R5: A one-cycle `wake_evt` pulse during power-down re-enables the clock on the next cycle, and the clock stays on while `pwr_down` remains high. Dropping `pwr_down` also re-enables the clock and clears the effect of the earlier wake event.
- R6: With auto=1, shutdown raises `bus_dis_req` and keeps the clock on until `bus_dis_ack` is sampled high. The clock then stops with the request still high. The request falls on the cycle the clock is re-enabled.
- R7: If the clock is wanted again while a drain request is unanswered, the shutdown is abandoned: the clock stays on and the request falls one cycle later.
- R8: Reads at `reg_addr`=1 return the applied clock enable in bit 0, the drain request in bit 1 and zeros above. The applied enable can lag the control word.
- R9: Bits selected by `TIE_MASK` read as the matching `TIE_VAL` bits and ignore writes.
- R10: `clk_out` is high only during the high phase of `clk_base`. Its enable is taken only while `clk_base` is low, so every pulse is a full base-clock high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock to be gated |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | 0 selects the control word, 1 selects the status word |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for the selected word |
| pwr_down | input | 1 | Chip-wide power-down request |
| wake_evt | input | 1 | Wake event |
| bus_dis_req | output | 1 | Bus drain request |
| bus_dis_ack | input | 1 | Bus drained acknowledge |
| clk_en | output | 1 | Applied clock enable |
| clk_out | output | 1 | Gated branch clock |

## Verification
Directed sequences cover each way the clock can stop: run cleared without auto, power-down with and without the wake bit, and the drain path with a late acknowledge. Each case is paired with the event that should bring the clock back, so the sequences show which control bit actually gates the clock. A cancelled drain, where run returns before the acknowledge, separates abort from completion. Random control writes, power-down toggles, wake pulses and acknowledge noise are then compared every cycle against a bench model. This catches ordering slips between a control write and the state it affects.

// File: rtl/branch_clk_gate.sv
module branch_clk_gate #(
  parameter logic [2:0] TIE_MASK = 3'b000,
  parameter logic [2:0] TIE_VAL  = 3'b000,
  parameter int         DW       = 32
) (
  input  logic          clk_base,
  input  logic          rst_n,
  input  logic          reg_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          pwr_down,
  input  logic          wake_evt,
  output logic          bus_dis_req,
  input  logic          bus_dis_ack,
  output logic          clk_en,
  output logic          clk_out
);

  localparam logic [2:0] CFG_RST = 3'b001;

  typedef enum logic [1:0] {S_ON, S_DRAIN, S_OFF} st_t;

  st_t        st_q, st_d;
  logic [2:0] cfg_q, cfg;
  logic       run, auto, wk, woke_q, sleep, target, req_q, gate_l, cfg_wr;

  assign cfg    = (cfg_q & ~TIE_MASK) | (TIE_VAL & TIE_MASK);
  assign run    = cfg[0];
  assign auto   = cfg[1];
  assign wk     = cfg[2];
  assign cfg_wr = wr_en && !reg_addr;
  assign sleep  = wk && pwr_down && !woke_q && !wake_evt;
  assign target = run && !sleep;

  always_ff @(posedge clk_base or negedge rst_n)
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_wr) cfg_q <= wr_data[2:0];

  always_ff @(posedge clk_base or negedge rst_n)
    if (!rst_n) woke_q <= 1'b0;
    else        woke_q <= pwr_down && (woke_q || wake_evt);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_ON:    if (!target) st_d = auto ? S_DRAIN : S_OFF;
      S_DRAIN: if (target) st_d = S_ON;
               else if (bus_dis_ack || !auto) st_d = S_OFF;
      S_OFF:   if (target) st_d = S_ON;
      default: st_d = S_ON;
    endcase
  end

  always_ff @(posedge clk_base or negedge rst_n)
    if (!rst_n) begin
      st_q  <= S_ON;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= (st_d == S_DRAIN) || (req_q && st_d != S_ON);
    end

  assign clk_en      = (st_q != S_OFF);
  assign bus_dis_req = req_q;
  assign rd_data     = reg_addr ? {{(DW-2){1'b0}}, req_q, clk_en}
                                : {{(DW-3){1'b0}}, cfg};

  always_latch
    if (!clk_base) gate_l = clk_en;

  assign clk_out = clk_base & gate_l;

  assert_run_off_R3: assert property (@(posedge clk_base) disable iff (!rst_n)
    (!run && !auto) |=> !clk_en);

  assert_pd_ignored_R4: assert property (@(posedge clk_base) disable iff (!rst_n)
    (run && !wk && !cfg_wr) |=> clk_en);

  assert_wake_on_R5: assert property (@(posedge clk_base) disable iff (!rst_n)
    (run && wk && wake_evt && !cfg_wr) |=> clk_en);

  assert_off_after_ack_R6: assert property (@(posedge clk_base) disable iff (!rst_n)
    $fell(clk_en) |-> (!$past(auto) || $past(bus_dis_ack && bus_dis_req)));

  assert_abort_R7: assert property (@(posedge clk_base) disable iff (!rst_n)
    (st_q == S_DRAIN && target) |=> (clk_en && !bus_dis_req));

  assert_gate_phase_R10: assert property (@(posedge clk_base) disable iff (!rst_n)
    gate_l == clk_en);

endmodule

// File: tb/branch_clk_gate_test.sv
module branch_clk_gate_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_addr = 1'b0, wr_en = 1'b0, t_wr = 1'b0;
  logic [31:0] wr_data = '0;
  logic pd = 1'b0, wake = 1'b0, ack = 1'b0;
  logic [31:0] rd_data, t_rd;
  logic req, en, cko, t_req, t_en, t_cko;

  int checks = 0, fails = 0;
  logic [2:0] m_cfg = 3'b001;
  int m_st = 0;
  logic m_woke = 1'b0, m_req = 1'b0, prev_en = 1'b1;

  always #5 clk = ~clk;

  branch_clk_gate uut (.clk_base(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pwr_down(pd), .wake_evt(wake),
    .bus_dis_req(req), .bus_dis_ack(ack), .clk_en(en), .clk_out(cko));

  branch_clk_gate #(.TIE_MASK(3'b011), .TIE_VAL(3'b001)) uut_tied (.clk_base(clk),
    .rst_n(rst_n), .reg_addr(1'b0), .wr_en(t_wr), .wr_data(wr_data), .rd_data(t_rd),
    .pwr_down(1'b0), .wake_evt(1'b0), .bus_dis_req(t_req), .bus_dis_ack(1'b0),
    .clk_en(t_en), .clk_out(t_cko));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic m_en();
    return m_st != 2;
  endfunction

  function automatic logic [31:0] m_rd(logic a);
    return a ? {30'b0, m_req, m_en()} : {29'b0, m_cfg};
  endfunction

  task automatic model_tick();
    logic tgt;
    int nst;
    tgt = m_cfg[0] && !(m_cfg[2] && pd && !m_woke && !wake);
    nst = m_st;
    case (m_st)
      0: if (!tgt) nst = m_cfg[1] ? 1 : 2;
      1: if (tgt) nst = 0; else if (ack || !m_cfg[1]) nst = 2;
      default: if (tgt) nst = 0;
    endcase
    m_req  = (nst == 1) || (m_req && nst != 0);
    m_st   = nst;
    m_woke = pd && (m_woke || wake);
    if (wr_en && !reg_addr) m_cfg = wr_data[2:0];
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    #2;
    chk("R10 high phase", {31'b0, cko}, {31'b0, prev_en});
    @(negedge clk);
    #1;
    chk("R10 low phase", {31'b0, cko}, 32'd0);
    chk("R8 model enable", {31'b0, en}, {31'b0, m_en()});
    chk("R6 model request", {31'b0, req}, {31'b0, m_req});
    chk("R2 model read", rd_data, m_rd(reg_addr));
    prev_en = en;
  endtask

  task automatic wr(logic [31:0] v);
    wr_en = 1'b1; reg_addr = 1'b0; wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4321);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 control word", rd_data, 32'h1);
    chk("R1 enable", {31'b0, en}, 32'd1);
    chk("R1 request", {31'b0, req}, 32'd0);
    reg_addr = 1'b1; #1;
    chk("R1 status", rd_data, 32'h1);
    reg_addr = 1'b0;

    wr(32'h0);
    chk("R2 readback", rd_data, 32'h0);
    reg_addr = 1'b1; #1;
    chk("R8 status lags", rd_data, 32'h1);
    reg_addr = 1'b0;
    step();
    chk("R3 run cleared", {31'b0, en}, 32'd0);
    wr(32'hFFFF_FFF9);
    chk("R2 reserved zero", rd_data, 32'h1);
    step();
    chk("R3 run set", {31'b0, en}, 32'd1);

    pd = 1'b1;
    repeat (3) step();
    chk("R4 pd ignored", {31'b0, en}, 32'd1);
    wr(32'h5);
    step();
    chk("R4 pd stops", {31'b0, en}, 32'd0);
    wake = 1'b1; step(); wake = 1'b0;
    chk("R5 wake event", {31'b0, en}, 32'd1);
    repeat (3) step();
    chk("R5 stays awake", {31'b0, en}, 32'd1);
    pd = 1'b0; step(); pd = 1'b1; step();
    chk("R5 re-sleep", {31'b0, en}, 32'd0);
    pd = 1'b0; step();
    chk("R5 pd cleared", {31'b0, en}, 32'd1);

    t_wr = 1'b1; wr_data = 32'h6;
    step();
    t_wr = 1'b0;
    chk("R9 tied read", t_rd, 32'h5);
    step();
    chk("R9 tied run", {31'b0, t_en}, 32'd1);

    wr(32'h3);
    wr(32'h2);
    step();
    chk("R6 drain request", {31'b0, req}, 32'd1);
    reg_addr = 1'b1; #1;
    chk("R8 status drain", rd_data, 32'h3);
    reg_addr = 1'b0;
    repeat (2) step();
    chk("R6 waits for ack", {31'b0, en}, 32'd1);
    ack = 1'b1; step(); ack = 1'b0;
    chk("R6 stopped", {31'b0, en}, 32'd0);
    chk("R6 request held", {31'b0, req}, 32'd1);
    wr(32'h3);
    step();
    chk("R6 restart enable", {31'b0, en}, 32'd1);
    chk("R6 request dropped", {31'b0, req}, 32'd0);

    wr(32'h2);
    step();
    wr(32'h3);
    chk("R7 still on", {31'b0, en}, 32'd1);
    step();
    chk("R7 abort enable", {31'b0, en}, 32'd1);
    chk("R7 abort request", {31'b0, req}, 32'd0);

    for (int i = 0; i < 4000; i++) begin
      wr_en    = ($urandom % 8) == 0;
      reg_addr = $urandom % 2;
      wr_data  = $urandom;
      if (($urandom % 16) == 0) pd = ~pd;
      wake = ($urandom % 10) == 0;
      ack  = ($urandom % 3) == 0;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule